// File: doc/BRIEF.md
# GPIO Line Interrupt Aggregator

This block watches a bank of general-purpose input lines and folds them into a single interrupt request for a parent interrupt controller. Each line is first brought into the local clock domain through two flip-flops. A third flop keeps the previous synchronized value so that edges can be seen. Software picks the trigger of each line with three per-line bits: one selects edge or level sensing, one makes any edge count, and one sets the active direction.

Edge events are held in a per-line latch until software acknowledges them. To acknowledge, software writes the line's clear bit low and then high. Level events are not held: their status follows the synchronized input. A per-line enable bit gates each line's status into the combined request. A read-only status register shows the pending bits before the enables are applied.

All control registers sit on a simple single-cycle register bus. Each register holds one bit per line and 32 lines per word. Software sets a trigger mode only while the line is masked.

Top module: `gpio_irq_agg`

## Requirements
- R1: The address splits into two fields. The upper 3 bits select the register kind: 0 sense, 1 any-edge, 2 polarity, 3 enable, 4 clear, 5 status. The low `WIDX_W` bits give the word index. Line n is bit n%32 of word n/32. A read returns the stored bits of the addressed word, and positions with no line read 0.
- R2: A sense bit of 1 selects edge detection and 0 selects level detection.
- R3: In edge mode with the any-edge bit at 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge. The other direction is ignored. An input change set up before clock edge k shows in status after edge k+2.
- R4: In edge mode with the any-edge bit at 1, both directions latch, whatever the polarity bit holds.
- R5: In level mode the status bit follows the synchronized input and is never latched. Polarity 1 means active high and 0 means active low. The status lags the input by two clock edges, and the any-edge bit has no effect.
- R6: A 0-to-1 change of a line's stored clear bit clears that line's edge latch one edge later. Writing 1 over a clear bit that already holds 1 leaves the latch set.
- R7: `irq_out` is the OR of all status bits ANDed with their enable bits. A line whose enable is 0 never raises it.
- R8: An edge that arrives in the same cycle as a clear transition leaves the latch set.
- R9: After reset, all control registers and edge latches are 0 and `irq_out` is 0.
- R10: A write to the status address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | NUM_LINES | Asynchronous input lines |
| bus_we | input | 1 | Register write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W | Register kind and word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The delicate overlap is a new qualifying edge arriving in the same cycle that a clear transition is taking effect on the same line. The bench provokes this by changing the input one cycle before it writes the clear bit from 0 to 1. That timing puts the synchronized rising edge and the clear pulse on the same clock edge. The result is judged by reading status afterwards, where the latch must still be set, and by a behavioural per-line model that is compared with `irq_out` on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int LINES_PER_WORD = 32;

  typedef enum logic [2:0] {
    RK_SENSE = 3'd0,
    RK_BOTH  = 3'd1,
    RK_POL   = 3'd2,
    RK_EN    = 3'd3,
    RK_CLR   = 3'd4,
    RK_STAT  = 3'd5
  } reg_kind_e;

  // Edge qualification: mode, any-edge and direction select the event.
  function automatic logic edge_qualify(logic sense, logic both, logic pol,
                                        logic rise, logic fall);
    logic dir_hit;
    dir_hit = pol ? rise : fall;
    return sense & (both ? (rise | fall) : dir_hit);
  endfunction

  // Level qualification: polarity picks active high or active low.
  function automatic logic level_qualify(logic pol, logic lvl);
    return pol ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prev
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign prev = s3_q;
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic prev,
  input  logic sense,
  input  logic both,
  input  logic pol,
  input  logic clr,
  output logic edge_hit,
  output logic clr_pulse,
  output logic latch_q,
  output logic pending
);
  logic clr_q;
  logic rise, fall;

  assign rise      = lvl & ~prev;
  assign fall      = ~lvl & prev;
  assign edge_hit  = edge_qualify(sense, both, pol, rise, fall);
  assign clr_pulse = clr & ~clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      clr_q   <= clr;
      latch_q <= edge_hit | (latch_q & ~clr_pulse);
    end
  end

  assign pending = sense ? latch_q : level_qualify(pol, lvl);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N      = 40,
  parameter int WORDS  = 2,
  parameter int WIDX_W = 1,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      sense_q,
  output logic [N-1:0]      both_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      clr_q
);
  localparam int PADW = WORDS * LINES_PER_WORD;

  reg_kind_e         kind;
  logic [WIDX_W-1:0] widx;

  assign kind = reg_kind_e'(bus_addr[ADDR_W-1:WIDX_W]);
  assign widx = bus_addr[WIDX_W-1:0];

  for (genvar i = 0; i < N; i++) begin : g_line
    localparam int W = i / LINES_PER_WORD;
    localparam int B = i % LINES_PER_WORD;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sense_q[i] <= 1'b0;
        both_q[i]  <= 1'b0;
        pol_q[i]   <= 1'b0;
        en_q[i]    <= 1'b0;
        clr_q[i]   <= 1'b0;
      end else if (bus_we && (int'(widx) == W)) begin
        case (kind)
          RK_SENSE: sense_q[i] <= bus_wdata[B];
          RK_BOTH:  both_q[i]  <= bus_wdata[B];
          RK_POL:   pol_q[i]   <= bus_wdata[B];
          RK_EN:    en_q[i]    <= bus_wdata[B];
          RK_CLR:   clr_q[i]   <= bus_wdata[B];
          default:  ;
        endcase
      end
    end
  end

  logic [PADW-1:0] sel_pad;

  always_comb begin
    sel_pad = '0;
    case (kind)
      RK_SENSE: sel_pad[N-1:0] = sense_q;
      RK_BOTH:  sel_pad[N-1:0] = both_q;
      RK_POL:   sel_pad[N-1:0] = pol_q;
      RK_EN:    sel_pad[N-1:0] = en_q;
      RK_CLR:   sel_pad[N-1:0] = clr_q;
      RK_STAT:  sel_pad[N-1:0] = status;
      default:  sel_pad = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(widx) < WORDS)
      bus_rdata = sel_pad[int'(widx)*LINES_PER_WORD +: LINES_PER_WORD];
  end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int NUM_LINES  = 40,
  localparam int WORDS     = (NUM_LINES + 31) / 32,
  localparam int WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W    = 3 + WIDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] lvl_v, prev_v;
  logic [NUM_LINES-1:0] sense_v, both_v, pol_v, en_v, clr_v;
  logic [NUM_LINES-1:0] edge_hit_v, clr_pulse_v, latch_v, pending_v;

  gpio_sync_bank #(.N(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(line_in), .lvl(lvl_v), .prev(prev_v)
  );

  gpio_irq_regs #(
    .N(NUM_LINES), .WORDS(WORDS), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(pending_v),
    .sense_q(sense_v), .both_q(both_v), .pol_q(pol_v), .en_q(en_v),
    .clr_q(clr_v)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_det
    gpio_line_detect u_det (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_v[i]), .prev(prev_v[i]),
      .sense(sense_v[i]), .both(both_v[i]), .pol(pol_v[i]), .clr(clr_v[i]),
      .edge_hit(edge_hit_v[i]), .clr_pulse(clr_pulse_v[i]),
      .latch_q(latch_v[i]), .pending(pending_v[i])
    );
  end

  assign irq_out = |(pending_v & en_v);
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
  parameter int N = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] sense,
  input logic [N-1:0] en,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] clr_pulse,
  input logic [N-1:0] latch,
  input logic         irq
);
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq); // R7

  for (genvar i = 0; i < N; i++) begin : g_ln
    AST_EDGE_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[i] |=> latch[i]); // R8
    AST_CLEAR_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse[i] && !edge_hit[i]) |=> !latch[i]); // R6
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (latch[i] && !clr_pulse[i]) |=> latch[i]); // R6
    AST_LEVEL_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !sense[i] |-> !edge_hit[i]); // R2
  end
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sense(sense_v), .en(en_v),
  .edge_hit(edge_hit_v), .clr_pulse(clr_pulse_v), .latch(latch_v),
  .irq(irq_out)
);

// File: tb/tb_gpio_irq_agg.sv
module tb_gpio_irq_agg;
  localparam int NL = 40;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] line_in = '0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_agg #(.NUM_LINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // Behavioural reference: shadow registers and per-line state.
  bit [63:0] sh_sense, sh_both, sh_pol, sh_en, sh_clr;
  bit [NL-1:0] m_a, m_b, m_c, m_latch, m_clrprev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_sense = 0; sh_both = 0; sh_pol = 0; sh_en = 0; sh_clr = 0;
      m_a = 0; m_b = 0; m_c = 0; m_latch = 0; m_clrprev = 0;
    end else begin
      bit [NL-1:0] nl;
      for (int i = 0; i < NL; i++) begin
        bit up, dn, hit, wipe;
        up = m_b[i] && !m_c[i];
        dn = !m_b[i] && m_c[i];
        hit = 0;
        if (sh_sense[i]) begin
          if (sh_both[i]) hit = up || dn;
          else if (sh_pol[i]) hit = up;
          else hit = dn;
        end
        wipe = sh_clr[i] && !m_clrprev[i];
        nl[i] = hit ? 1'b1 : (wipe ? 1'b0 : m_latch[i]);
      end
      m_clrprev = sh_clr[NL-1:0];
      m_latch = nl;
      m_c = m_b; m_b = m_a; m_a = line_in;
      if (bus_we) begin
        int base;
        base = 32 * int'(bus_addr[0]);
        for (int k = 0; k < 32; k++) begin
          case (int'(bus_addr[3:1]))
            0: sh_sense[base+k] = bus_wdata[k];
            1: sh_both[base+k]  = bus_wdata[k];
            2: sh_pol[base+k]   = bus_wdata[k];
            3: sh_en[base+k]    = bus_wdata[k];
            4: sh_clr[base+k]   = bus_wdata[k];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic bit exp_pend(int i);
    if (sh_sense[i]) return m_latch[i];
    if (sh_pol[i]) return m_b[i];
    return !m_b[i];
  endfunction

  function automatic logic [31:0] exp_stat(int w);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++)
      if (w*32 + k < NL) v[k] = exp_pend(w*32 + k);
    return v;
  endfunction

  function automatic bit exp_irq();
    for (int i = 0; i < NL; i++)
      if (sh_en[i] && exp_pend(i)) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (started && rst_n && !done) chk("R7 irq per cycle", {31'd0, irq_out}, {31'd0, exp_irq()});

  task automatic wr(input int kind, input int word, input logic [31:0] d);
    bus_addr = AW'(kind*2 + word); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int kind, input int word, output logic [31:0] v);
    bus_addr = AW'(kind*2 + word);
    #1 v = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stat_bit(input string tag, input int line, input bit exp);
    logic [31:0] v;
    rd(5, line/32, v);
    chk(tag, {31'd0, v[line%32]}, {31'd0, exp});
    chk({tag, " model"}, v, exp_stat(line/32));
  endtask

  initial begin
    logic [31:0] v;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;
    // R9 reset state
    chk("R9 irq after reset", {31'd0, irq_out}, 32'd0);
    rd(3, 0, v); chk("R9 enable reset", v, 32'd0);
    rd(0, 1, v); chk("R9 sense reset", v, 32'd0);
    // line 3 rising edge, line 7 level high
    wr(0, 0, 32'h08);
    wr(2, 0, 32'h88);
    wr(3, 0, 32'h08);
    line_in[3] = 1'b1;
    wait_n(2); stat_bit("R3 not yet latched", 3, 0);
    wait_n(1); stat_bit("R3 rise latched at third edge", 3, 1);
    chk("R7 irq on enabled line", {31'd0, irq_out}, 32'd1);
    line_in[3] = 1'b0; wait_n(4);
    stat_bit("R3 falling ignored, latch kept", 3, 1);
    // R6 clear by 0->1
    wr(4, 0, 32'h08); wait_n(2);
    stat_bit("R6 clear transition", 3, 0);
    line_in[3] = 1'b1; wait_n(4);
    stat_bit("R3 retrigger", 3, 1);
    wr(4, 0, 32'h08); wait_n(2);
    stat_bit("R6 write 1 over 1 keeps latch", 3, 1);
    // R8 edge coincident with clear
    wr(4, 0, 32'h00);
    line_in[3] = 1'b0; wait_n(4);
    line_in[3] = 1'b1;
    @(negedge clk);
    wr(4, 0, 32'h08);
    @(negedge clk);
    stat_bit("R8 edge with clear retained", 3, 1);
    wr(4, 0, 32'h00); wr(4, 0, 32'h08); wait_n(2);
    stat_bit("R6 clear after coincidence", 3, 0);
    // R4 both edges on line 5 with polarity 0
    wr(0, 0, 32'h28);
    wr(1, 0, 32'hA0);
    wr(3, 0, 32'hA8);
    line_in[5] = 1'b1; wait_n(4);
    stat_bit("R4 rise with polarity 0", 5, 1);
    wr(4, 0, 32'h00); wr(4, 0, 32'h20); wait_n(2);
    stat_bit("R6 clear line 5", 5, 0);
    line_in[5] = 1'b0; wait_n(4);
    stat_bit("R4 fall latched", 5, 1);
    wr(4, 0, 32'h00); wr(4, 0, 32'h20); wait_n(2);
    // R5 level high on line 7 (any-edge bit set, ignored)
    stat_bit("R5 level idle low", 7, 0);
    line_in[7] = 1'b1; wait_n(1);
    stat_bit("R5 not yet visible", 7, 0);
    wait_n(1); stat_bit("R5 level follows input", 7, 1);
    line_in[7] = 1'b0; wait_n(2);
    stat_bit("R5 level not latched", 7, 0);
    // R2 switch line 5 to level: active low with input 0
    wr(0, 0, 32'h08); wait_n(1);
    stat_bit("R2 level mode selected", 5, 1);
    wr(3, 0, 32'h00);
    // R1 word 1: line 35 falling edge
    wr(0, 1, 32'h08);
    rd(0, 1, v); chk("R1 word1 readback", v, 32'h08);
    line_in[35] = 1'b1; wait_n(4);
    stat_bit("R1 R3 rise ignored on falling line", 35, 0);
    line_in[35] = 1'b0; wait_n(4);
    stat_bit("R1 R3 fall latched on line 35", 35, 1);
    chk("R7 masked line quiet", {31'd0, irq_out}, 32'd0);
    wr(3, 1, 32'h08); wait_n(1);
    chk("R7 enabled word1 line", {31'd0, irq_out}, 32'd1);
    wr(3, 1, 32'h00); wait_n(1);
    chk("R7 masked again", {31'd0, irq_out}, 32'd0);
    // R10 status not writable
    wr(5, 1, 32'h0); wait_n(1);
    stat_bit("R10 status write ignored", 35, 1);
    wait_n(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule